// File: doc/BRIEF.md
# Keyboard/Mouse Port Interrupt Generator

This block produces the interrupt lines for a keyboard/mouse serial port. The port core reports two events: a byte has finished transmitting, and a valid byte has arrived. The block keeps one raw pending flag for each of these two sources. It also watches the register bus so it can see accesses to the data register and writes to the control register. Two enable bits, held in the control register, gate the raw flags onto a receive interrupt and a transmit interrupt. A third output is high while either gated interrupt is high.

Each source has its own clearing rule. A read of the data register clears the receive flag. A write to the data register clears the transmit flag, but only when that flag is already pending and its enable is on. If a set event arrives in the same cycle as a clearing access, the set wins, so no event is lost.

A status word shows both the gated and the raw flags, for an interrupt status register read. The serial shifting, the line protocol and the bus fabric sit outside this block.

Top module: `kbd_irq_gen`

## Requirements
- R1: On a clock edge with `rst` high, both raw flags and both enable bits become 0, so `irq_status`, `rx_irq`, `tx_irq` and `any_irq` are all 0 after that edge.
- R2: A cycle with `tx_done` high sets the raw transmit flag, which appears at `irq_status[3]` after that edge.
- R3: A selected write to address `DATA_ADDR` clears the raw transmit flag when that flag is set and the transmit enable is 1. When the enable is 0, the flag is left unchanged.
- R4: A cycle with `rx_valid` high sets the raw receive flag, which appears at `irq_status[2]` after that edge.
- R5: A selected read of `DATA_ADDR` clears the raw receive flag. Writes to `DATA_ADDR` do not clear it, and the receive enable has no effect on clearing.
- R6: When a set event and a clearing access for the same source fall in the same cycle, the flag is 1 after the edge.
- R7: A selected write to `CTRL_ADDR` loads the receive enable from `bus_wdata[0]` and the transmit enable from `bus_wdata[1]`.
- R8: `rx_irq` equals the raw receive flag AND the receive enable, and `tx_irq` equals the raw transmit flag AND the transmit enable. These are reported as `irq_status[0]` and `irq_status[1]`. A change to an enable bit shows on these outputs right after the edge at which the control write takes effect.
- R9: `any_irq` is high exactly when `rx_irq` or `tx_irq` is high.
- R10: Bus accesses with `bus_sel` low, and writes to any address other than `DATA_ADDR` or `CTRL_ADDR`, change neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | One-cycle pulse: transmission complete |
| rx_valid | input | 1 | One-cycle pulse: valid byte received |
| bus_sel | input | 1 | Register bus select for this peripheral |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| rx_irq | output | 1 | Gated receive interrupt |
| tx_irq | output | 1 | Gated transmit interrupt |
| any_irq | output | 1 | OR of the gated interrupts |
| irq_status | output | 4 | {raw tx, raw rx, gated tx, gated rx} |

## Verification
The hardest situation to reach is a set event and a clearing access landing in exactly the same cycle. The bench reaches it by driving `tx_done` together with a data write, and `rx_valid` together with a data read, in one cycle, with the flag already pending and enabled. A second hard case is a data write with the transmit flag pending but disabled. The bench reaches it by setting the flag while the enables are still 0 after reset, then writing the data register before it writes the control register.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
  localparam int N_SRC  = 2;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  typedef struct packed {
    logic dat_wr;
    logic dat_rd;
    logic ctl_wr;
  } bus_hit_t;
endpackage

// File: rtl/kbd_irq_decode.sv
module kbd_irq_decode
  import kbd_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output bus_hit_t          hit
);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTRL_ADDR);

  always_comb begin
    hit.dat_wr = sel && wr && (addr == DAT_A);
    hit.dat_rd = sel && rd && (addr == DAT_A);
    hit.ctl_wr = sel && wr && (addr == CTL_A);
  end
endmodule

// File: rtl/kbd_irq_flags.sv
module kbd_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)           flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // set has priority
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    // R6: a set event always leaves the flag pending
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_o[i]);
    a_r6_clear_alone: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/kbd_irq_mask.sv
module kbd_irq_mask #(
  parameter int N      = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      en_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       en_o[i] <= 1'b0;
      else if (wr_i) en_o[i] <= wdata_i[i];
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen
  import kbd_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DATA_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              any_irq,
  output logic [3:0]        irq_status
);
  bus_hit_t         hit;
  logic [N_SRC-1:0] raw, en, set_v, clr_v, gated;

  kbd_irq_decode #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .hit(hit));

  kbd_irq_mask #(.N(N_SRC), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .wr_i(hit.ctl_wr), .wdata_i(bus_wdata), .en_o(en));

  always_comb begin
    set_v[SRC_RX] = rx_valid;
    set_v[SRC_TX] = tx_done;
    clr_v[SRC_RX] = hit.dat_rd;
    // transmit clear only takes effect on a pending, enabled flag
    clr_v[SRC_TX] = hit.dat_wr && raw[SRC_TX] && en[SRC_TX];
  end

  kbd_irq_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flag_o(raw));

  assign gated      = raw & en;
  assign rx_irq     = gated[SRC_RX];
  assign tx_irq     = gated[SRC_TX];
  assign any_irq    = |gated;
  assign irq_status = {raw[SRC_TX], raw[SRC_RX], gated[SRC_TX], gated[SRC_RX]};

  // R3: data write with transmit disabled leaves the transmit flag
  a_r3_tx_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (hit.dat_wr && !irq_status[1] && !tx_done) |=> (irq_status[3] == $past(irq_status[3])));
  // R3: enabled pending transmit flag is cleared by a data write
  a_r3_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (hit.dat_wr && irq_status[1] && !tx_done) |=> !irq_status[3]);
  // R5: data read drops the receive flag
  a_r5_rx_read_clears: assert property (@(posedge clk) disable iff (rst)
    (hit.dat_rd && !rx_valid) |=> !irq_status[2]);
  // R8: a gated interrupt needs its raw flag
  a_r8_gated_needs_raw: assert property (@(posedge clk) disable iff (rst)
    (!irq_status[0] || irq_status[2]) && (!irq_status[1] || irq_status[3]));
  // R10: no access and no event leaves everything still
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel && !tx_done && !rx_valid) |=> $stable(irq_status));
endmodule

// File: tb/test_kbd_irq_gen.sv
`timescale 1ns/1ps
module test_kbd_irq_gen;
  logic clk = 0, rst = 1;
  logic tx_done = 0, rx_valid = 0, bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic rx_irq, tx_irq, any_irq;
  logic [3:0] irq_status;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  kbd_irq_gen i_kbd_irq_gen (
    .clk(clk), .rst(rst), .tx_done(tx_done), .rx_valid(rx_valid),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .any_irq(any_irq), .irq_status(irq_status));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] got = {any_irq, tx_irq, rx_irq, irq_status};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic bus(logic sel, logic wr, logic rd, logic [3:0] a, logic [7:0] d);
    bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic pulse(logic t, logic r);
    tx_done = t; rx_valid = r; tick(); tx_done = 0; rx_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  // result vector: {any, tx_irq, rx_irq, raw_tx, raw_rx, gated_tx, gated_rx}
  task automatic t_reset();
    do_reset();
    chk("R1 reset", 7'b000_0000);
  endtask

  task automatic t_tx();
    do_reset();
    pulse(1, 0);             chk("R2 tx set", 7'b000_1000);
    bus(1, 1, 0, 0, 8'h00);  chk("R3 tx hold disabled", 7'b000_1000);
    bus(1, 1, 0, 1, 8'h02);  chk("R7 R8 R9 tx enable", 7'b110_1010);
    bus(1, 1, 0, 0, 8'h00);  chk("R3 tx cleared", 7'b000_0000);
    bus(1, 1, 0, 0, 8'h00);  chk("R3 tx clear idle", 7'b000_0000);
  endtask

  task automatic t_rx();
    do_reset();
    pulse(0, 1);             chk("R4 rx set", 7'b000_0100);
    bus(1, 1, 0, 0, 8'h00);  chk("R5 write keeps rx", 7'b000_0100);
    bus(1, 1, 0, 1, 8'h01);  chk("R7 R8 R9 rx enable", 7'b101_0101);
    bus(1, 0, 1, 1, 8'h00);  chk("R10 read ctrl no clear", 7'b101_0101);
    bus(1, 0, 1, 0, 8'h00);  chk("R5 read clears", 7'b000_0000);
    bus(1, 1, 0, 1, 8'h00);
    pulse(0, 1);
    bus(1, 0, 1, 0, 8'h00);  chk("R5 read clears disabled", 7'b000_0000);
  endtask

  task automatic t_set_wins();
    do_reset();
    bus(1, 1, 0, 1, 8'h03);
    pulse(1, 1);             chk("R6 prep", 7'b111_1111);
    tx_done = 1; bus(1, 1, 0, 0, 8'h00); tx_done = 0;
    chk("R6 tx set beats clear", 7'b111_1111);
    rx_valid = 1; bus(1, 0, 1, 0, 8'h00); rx_valid = 0;
    chk("R6 rx set beats clear", 7'b111_1111);
  endtask

  task automatic t_mask_ignore();
    do_reset();
    pulse(1, 1);             chk("R8 raw only", 7'b000_1100);
    bus(1, 1, 0, 5, 8'h03);  chk("R10 other addr", 7'b000_1100);
    bus(0, 1, 0, 1, 8'h03);  chk("R10 unselected write", 7'b000_1100);
    bus(1, 1, 0, 1, 8'h02);  chk("R8 tx only gated", 7'b110_1110);
    bus(0, 0, 1, 0, 8'h00);  chk("R10 unselected read", 7'b110_1110);
    bus(1, 1, 0, 1, 8'h00);  chk("R9 all masked", 7'b000_1100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_tx();
    t_rx();
    t_set_wins();
    t_mask_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule